// File: doc/BRIEF.md
# Double-Buffer Circular DMA Channel

This block is one peripheral-to-memory DMA channel that runs forever in a ping-pong mode. A peripheral offers data words on a valid/ready stream. The channel forwards each word to a memory write port, at an address inside one of two buffer regions. Both regions use the same programmed item count. When the count for the active region runs out, the channel switches to the other region, reloads the count and keeps going without help from software. Meanwhile another agent drains the region that was just filled.

Each completed region produces a one-cycle completion pulse, which can trigger a downstream engine, and sets a sticky flag. Software clears that flag by writing a mask to a clear register. The channel stops only when software drops its enable.

Back-pressure rules: the channel holds no data of its own. A word moves in the cycle where `per_valid`, `mem_ready` and the enable are all high. `mem_valid` follows `per_valid` and `per_ready` follows `mem_ready`, both gated by the enable. The peripheral must hold `per_data` stable while `per_valid` is high and `per_ready` is low.

Register map:

| Offset | Register | Access | Contents |
|---|---|---|---|
| 0 | control | read/write | bit 0 enable, bits 2:1 item size code |
| 1 | count | read/write | items per region |
| 2 | base A | read/write | base address of region 0 |
| 3 | base B | read/write | base address of region 1 |
| 4 | clear | write | mask; bit 0 clears the flag |
| 5 | status | read | bit 0 flag, bit 1 active region |
| 6 | remaining | read | items left in the active region |

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset `tc_flag`, `tc_pulse`, `cur_target`, `mem_valid` and `per_ready` are all 0.
- R2: While the enable (control bit 0) is 0, `mem_valid` and `per_ready` stay 0, and no word moves. The remaining count (offset 6) is left unchanged.
- R3: While enabled, `mem_valid` equals `per_valid` and `per_ready` equals `mem_ready`. `mem_data` equals `per_data`.
- R4: The write address of item k (counting from 0) within a region is that region's base plus k times the item size. Size codes 0, 1 and 2 select 1, 2 and 4 bytes; code 3 acts as 4 bytes.
- R5: After the count-th transfer into a region, `tc_pulse` is high for exactly the next cycle. The count then reloads from the count register and transfers continue with no register access.
- R6: At the same clock edge as the last transfer of a region, `cur_target` toggles between 0 and 1. Status bit 1 reads the same value, and the next address uses the other base.
- R7: `tc_flag` (status bit 0) is set by each region completion and stays set until it is cleared.
- R8: A write to the clear register (offset 4) with bit 0 set clears `tc_flag`. A write with bit 0 clear leaves the flag unchanged.
- R9: If a clear write and a region completion fall on the same edge, `tc_flag` ends up set.
- R10: Writing enable 1 while the channel is disabled restarts it at region 0, item 0, with a full count.
- R11: The hardware never clears the enable. Control bit 0 reads 1 after any number of region completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write offset |
| reg_wdata | input | AW | Register write data |
| reg_raddr | input | 3 | Register read offset |
| reg_rdata | output | AW | Register read data (combinational) |
| per_valid | input | 1 | Peripheral word valid |
| per_ready | output | 1 | Channel accepts peripheral word |
| per_data | input | DW | Peripheral word |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts write |
| mem_addr | output | AW | Memory byte address |
| mem_data | output | DW | Memory write data |
| tc_pulse | output | 1 | One-cycle region-complete pulse |
| tc_flag | output | 1 | Sticky region-complete flag |
| cur_target | output | 1 | Active region (0 or 1) |

## Verification
If the item counter goes wrong, the fault shows up within one region. `tc_pulse` arrives one cycle early or late against the count of accepted transfers, and the addresses that follow start from the wrong base. A wrong offset or size decode changes `mem_addr` on the very next transfer. A stuck region bit leaves the same base in use after a pulse. Flag-priority errors appear in the cycle right after a clear write that coincides with a completion.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;
  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_COUNT  = 3'd1,
    RA_BASE0  = 3'd2,
    RA_BASE1  = 3'd3,
    RA_CLEAR  = 3'd4,
    RA_STATUS = 3'd5,
    RA_REMAIN = 3'd6
  } reg_addr_e;

  localparam int REG_AW = 3;

  // Byte step for an item size code.
  function automatic logic [2:0] item_bytes(input logic [1:0] code);
    case (code)
      2'd0:    item_bytes = 3'd1;
      2'd1:    item_bytes = 3'd2;
      default: item_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dbuf_regs.sv
module dbuf_regs
  import dbuf_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [AW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [AW-1:0]     rd_data,
  input  logic              tc_set,
  input  logic              cur_tgt,
  input  logic [CW-1:0]     remain,
  output logic              en,
  output logic [1:0]        size_code,
  output logic [CW-1:0]     count,
  output logic [AW-1:0]     base0,
  output logic [AW-1:0]     base1,
  output logic              start,
  output logic              flag
);
  logic wr_ctrl, wr_clear;

  assign wr_ctrl  = wr_en && (wr_addr == RA_CTRL);
  assign wr_clear = wr_en && (wr_addr == RA_CLEAR);
  assign start    = wr_ctrl && wr_data[0] && !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      size_code <= 2'd0;
      count     <= '0;
      base0     <= '0;
      base1     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_CTRL:  begin
          en        <= wr_data[0];
          size_code <= wr_data[2:1];
        end
        RA_COUNT: count <= wr_data[CW-1:0];
        RA_BASE0: base0 <= wr_data;
        RA_BASE1: base1 <= wr_data;
        default:  ;
      endcase
    end
  end

  // A completion on the same edge as a clear takes priority.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flag <= 1'b0;
    else if (tc_set)                flag <= 1'b1;
    else if (wr_clear && wr_data[0]) flag <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL:   rd_data = AW'({size_code, en});
      RA_COUNT:  rd_data = AW'(count);
      RA_BASE0:  rd_data = base0;
      RA_BASE1:  rd_data = base1;
      RA_STATUS: rd_data = AW'({cur_tgt, flag});
      RA_REMAIN: rd_data = AW'(remain);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dbuf_engine.sv
module dbuf_engine
  import dbuf_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          beat,
  input  logic [1:0]    size_code,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  output logic [AW-1:0] addr,
  output logic          tgt,
  output logic [CW-1:0] remain,
  output logic          tc
);
  logic [AW-1:0] off_q;
  logic          last;

  assign last = (remain <= CW'(1));
  assign addr = (tgt ? base1 : base0) + off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      tgt    <= 1'b0;
      remain <= '0;
      tc     <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (start) begin
        off_q  <= '0;
        tgt    <= 1'b0;
        remain <= count;
      end else if (beat) begin
        if (last) begin
          off_q  <= '0;
          tgt    <= ~tgt;
          remain <= count;
          tc     <= 1'b1;
        end else begin
          off_q  <= off_q + AW'(item_bytes(size_code));
          remain <= remain - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbuf_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [AW-1:0]     reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [AW-1:0]     reg_rdata,
  input  logic              per_valid,
  output logic              per_ready,
  input  logic [DW-1:0]     per_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_data,
  output logic              tc_pulse,
  output logic              tc_flag,
  output logic              cur_target
);
  logic          en_w, start_w, beat_w;
  logic [1:0]    size_w;
  logic [CW-1:0] count_w, remain_w;
  logic [AW-1:0] base0_w, base1_w;

  assign mem_valid = en_w && per_valid;
  assign per_ready = en_w && mem_ready;
  assign mem_data  = per_data;
  assign beat_w    = en_w && per_valid && mem_ready;

  dbuf_regs #(.AW(AW), .CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
    .rd_addr(reg_raddr), .rd_data(reg_rdata),
    .tc_set(beat_w && (remain_w <= CW'(1)) && !start_w),
    .cur_tgt(cur_target), .remain(remain_w),
    .en(en_w), .size_code(size_w), .count(count_w),
    .base0(base0_w), .base1(base1_w), .start(start_w), .flag(tc_flag)
  );

  dbuf_engine #(.AW(AW), .CW(CW)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .start(start_w), .beat(beat_w), .size_code(size_w), .count(count_w),
    .base0(base0_w), .base1(base1_w),
    .addr(mem_addr), .tgt(cur_target), .remain(remain_w), .tc(tc_pulse)
  );
endmodule

// File: rtl/dbuf_dma_chan_chk.sv
module dbuf_dma_chan_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic mem_valid,
  input logic mem_ready,
  input logic per_ready,
  input logic tc_pulse,
  input logic tc_flag,
  input logic cur_target
);
  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!mem_valid && !per_ready));

  assert_pulse_after_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> $past(mem_valid && mem_ready));

  assert_swap_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (cur_target != $past(cur_target)));

  assert_flag_on_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> tc_flag);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse || $past(mem_valid && mem_ready));
endmodule

bind dbuf_dma_chan dbuf_dma_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en_w),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .per_ready(per_ready),
  .tc_pulse(tc_pulse), .tc_flag(tc_flag), .cur_target(cur_target)
);

// File: tb/dbuf_dma_chan_tb_top.sv
`timescale 1ns/1ps
module dbuf_dma_chan_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam logic [AW-1:0] B0 = 32'h0000_1000;
  localparam logic [AW-1:0] B1 = 32'h0000_2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_waddr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [2:0] reg_raddr = '0;
  logic [AW-1:0] reg_rdata;
  logic per_valid = 1'b0;
  logic per_ready;
  logic [DW-1:0] per_data = '0;
  logic mem_valid;
  logic mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic tc_pulse, tc_flag, cur_target;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  int m_cnt, m_sz, m_k, nbeat;
  bit m_tgt, m_flag;

  always #2.5 clk = ~clk;

  dbuf_dma_chan #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .per_valid(per_valid), .per_ready(per_ready), .per_data(per_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data),
    .tc_pulse(tc_pulse), .tc_flag(tc_flag), .cur_target(cur_target)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [AW-1:0] d);
    reg_raddr = a;
    #0.1;
    d = reg_rdata;
  endtask

  function automatic int step(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  task automatic start_chan(input int sz, input int cnt);
    wr(3'd0, 32'd0);
    wr(3'd1, cnt);
    wr(3'd0, (sz << 1) | 1);
    m_sz = sz; m_cnt = cnt; m_k = 0; m_tgt = 1'b0;
  endtask

  // One transfer; stall inserts a cycle with mem_ready low first.
  task automatic beat(input bit stall, input bit with_clear);
    logic [AW-1:0] exp_addr;
    bit last;
    @(negedge clk);
    nbeat++;
    per_valid = 1'b1;
    per_data = 32'hA500_0000 + nbeat;
    mem_ready = !stall;
    if (stall) begin
      #0.1;
      chk(mem_valid == 1'b1 && per_ready == 1'b0, "R3 stall", {mem_valid, per_ready}, 2'b10);
      @(negedge clk);
      mem_ready = 1'b1;
    end
    #0.1;
    exp_addr = (m_tgt ? B1 : B0) + m_k * step(m_sz);
    chk(mem_addr == exp_addr, "R4 address", mem_addr, exp_addr);
    chk(mem_data == per_data && per_ready, "R3 data", mem_data, per_data);
    if (with_clear) begin
      reg_wr = 1'b1; reg_waddr = 3'd4; reg_wdata = 32'd1;
    end
    @(negedge clk);
    per_valid = 1'b0; mem_ready = 1'b0; reg_wr = 1'b0;
    last = (m_k == m_cnt - 1);
    if (last) begin
      m_k = 0; m_tgt = !m_tgt; m_flag = 1'b1;
    end else begin
      m_k++;
      if (with_clear) m_flag = 1'b0;
    end
    chk(tc_pulse == last, "R5 pulse", tc_pulse, last);
    chk(cur_target == m_tgt, "R6 target", cur_target, m_tgt);
    chk(tc_flag == m_flag, last && with_clear ? "R9 set wins" : "R7 flag", tc_flag, m_flag);
    @(negedge clk);
    chk(tc_pulse == 1'b0, "R5 pulse width", tc_pulse, 0);
  endtask

  initial begin
    logic [AW-1:0] v;
    nbeat = 0; m_flag = 1'b0;
    #12;
    // R1 reset state
    chk(tc_flag == 0 && tc_pulse == 0 && cur_target == 0, "R1 reset status",
        {tc_flag, tc_pulse, cur_target}, 0);
    chk(mem_valid == 0 && per_ready == 0, "R1 reset handshake", {mem_valid, per_ready}, 0);
    rst_n = 1'b1;
    wr(3'd2, B0);
    wr(3'd3, B1);

    // Sweep sizes (including code 3) and counts
    for (int sz = 0; sz < 4; sz++) begin
      for (int cnt = 1; cnt <= 4; cnt++) begin
        start_chan(sz, cnt);
        wr(3'd4, 32'd1); m_flag = 1'b0;
        rd(3'd6, v);
        chk(v == cnt, "R10 full count", v, cnt);
        for (int b = 0; b < 2 * cnt + 1; b++) beat((b % 3) == 2, 1'b0);
        rd(3'd5, v);
        chk(v[1] == m_tgt, "R6 status bit", v[1], m_tgt);
        rd(3'd0, v);
        chk(v[0] == 1'b1, "R11 enable kept", v[0], 1);
      end
    end

    // R8 masked clear
    start_chan(2, 2);
    beat(0, 0); beat(0, 0);
    wr(3'd4, 32'd2);
    chk(tc_flag == 1'b1, "R8 mask bit0 clear keeps flag", tc_flag, 1);
    wr(3'd4, 32'd1); m_flag = 1'b0;
    chk(tc_flag == 1'b0, "R8 clear", tc_flag, 0);

    // R9 clear on completion edge
    beat(0, 0);
    beat(0, 1);
    chk(tc_flag == 1'b1, "R9 set wins", tc_flag, 1);
    // clear on non-completion edge takes effect
    beat(0, 1);
    chk(tc_flag == 1'b0, "R8 clear during transfer", tc_flag, 0);

    // R2 disabled: nothing moves
    rd(3'd6, v);
    wr(3'd0, 32'd4);
    @(negedge clk);
    per_valid = 1'b1; mem_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #0.1;
      chk(mem_valid == 0 && per_ready == 0, "R2 idle", {mem_valid, per_ready}, 0);
      @(negedge clk);
    end
    per_valid = 1'b0; mem_ready = 1'b0;
    begin
      logic [AW-1:0] v2;
      rd(3'd6, v2);
      chk(v2 == v, "R2 remaining unchanged", v2, v);
    end

    // R10 restart mid-region
    start_chan(1, 4);
    beat(0, 0); beat(0, 0); beat(0, 0); beat(0, 0); beat(0, 0);
    chk(cur_target == 1'b1, "R6 in region 1", cur_target, 1);
    wr(3'd0, 32'd2);
    wr(3'd0, 32'd3);
    m_k = 0; m_tgt = 1'b0;
    chk(cur_target == 1'b0, "R10 restart region 0", cur_target, 0);
    beat(0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule